// File: doc/BRIEF.md
# SD Host Vendor Register Bank

This block is a 32-bit register bank placed in front of an SD/eMMC host controller. It decodes a 4 KiB window. Offsets below 0x200 are a bank of vendor control words, and three of them have write side effects. The word at 0x000 holds a general value and carries a software reset trigger. The word at 0x010 is a PHY access port whose acknowledge bit is derived from its request bits. The word at 0x018 is an eMMC control word whose tuning bit clears itself.

Offsets from 0x200 to the top of the window go to a pass-through port that feeds a standard slot register set. The slot's read data and error answer that access in the same cycle, and the slot interrupt passes straight to the host. A software reset returns the bank to its power-on contents on the next clock edge. It also drives a one-cycle reset pulse to the attached slot controller.

Top module: `sdhost_vendor_regs`

## Requirements
- R1: An access is valid only with all four byte enables set (`req_be` = 4'b1111) and `req_addr[1:0]` = 0. Any other access asserts `rsp_err`, returns zero, changes no word and is not forwarded.
- R2: After reset, the word at 0x000 reads 0x00010000 and every other vendor word reads 0.
- R3: A valid write to 0x000 with bit 0 set restores every vendor word to its R2 value at the clock edge that ends the write.
- R4: The write in R3 makes `slot_rst` high for exactly the one cycle after that edge.
- R5: A write to 0x000 with bit 0 clear leaves that word unchanged.
- R6: At 0x010, the stored bit 26 is 1 when the written bit 24 (write request) or bit 25 (read request) is 1. Otherwise it is 0, whatever was written to it. All other bits are stored as written.
- R7: At 0x018, bit 15 is always stored as 0. All other bits are stored as written.
- R8: Every other vendor offset in 0x000..0x1FF stores the written word unchanged and reads it back.
- R9: A valid access at offset 0x200 or above raises `slot_valid` in the same cycle, with `slot_addr` = offset − 0x200. `rsp_rdata` and `rsp_err` then come from `slot_rdata` and `slot_err`.
- R10: `host_irq` equals `slot_irq` at all times.
- R11: A valid read of a vendor offset returns the stored word on `rsp_rdata` in the same cycle, with `rsp_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle |
| rsp_err | output | 1 | Error response, same cycle |
| slot_valid | output | 1 | Forwarded request strobe |
| slot_write | output | 1 | Forwarded direction |
| slot_addr | output | 12 | Offset relative to 0x200 |
| slot_wdata | output | 32 | Forwarded write data |
| slot_rdata | input | 32 | Slot read data |
| slot_err | input | 1 | Slot error response |
| slot_irq | input | 1 | Slot interrupt |
| slot_rst | output | 1 | One-cycle slot reset pulse |
| host_irq | output | 1 | Interrupt to host |

## Verification
Read data, error and the forwarded request are combinational, so the bench drives each access just after a falling edge and samples its response one time unit later, before the next rising edge. The effect of a write is due at the rising edge that ends it, so a read in a later cycle checks it. The software reset pulse is registered: it is checked high at the first falling edge after the resetting write and low at the falling edge after that. The sweeps write every vendor word and compute its expected readback arithmetically from its offset.

// File: rtl/sdv_pkg.sv
package sdv_pkg;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int BE_W       = DATA_W / 8;
    localparam int SLOT_BASE  = 'h200;
    localparam int VND_WORDS  = SLOT_BASE / BE_W;
    localparam int IDX_W      = $clog2(VND_WORDS);

    localparam logic [IDX_W-1:0] IDX_GEN  = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_PHY  = IDX_W'('h10 / BE_W);
    localparam logic [IDX_W-1:0] IDX_EMMC = IDX_W'('h18 / BE_W);

    localparam int BIT_SWR      = 0;
    localparam int BIT_PHY_WR   = 24;
    localparam int BIT_PHY_RD   = 25;
    localparam int BIT_PHY_ACK  = 26;
    localparam int BIT_TUNE     = 15;

    localparam logic [DATA_W-1:0] GEN_POR = 32'h0001_0000;
endpackage

// File: rtl/sdv_decode.sv
module sdv_decode
    import sdv_pkg::*;
(
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    output logic              bad,
    output logic              vnd_hit,
    output logic              slot_hit,
    output logic [IDX_W-1:0]  widx,
    output logic [ADDR_W-1:0] slot_off
);
    localparam int LSB_W = $clog2(BE_W);

    logic word_ok;
    logic in_slot;

    always_comb begin
        word_ok  = (be == {BE_W{1'b1}}) && (addr[LSB_W-1:0] == '0);
        in_slot  = (int'(addr) >= SLOT_BASE);
        bad      = valid && !word_ok;
        vnd_hit  = valid && word_ok && !in_slot;
        slot_hit = valid && word_ok && in_slot;
        widx     = addr[LSB_W +: IDX_W];
        slot_off = addr - ADDR_W'(SLOT_BASE);
    end
endmodule

// File: rtl/sdv_wr_fx.sv
module sdv_wr_fx
    import sdv_pkg::*;
(
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    output logic              store_en,
    output logic [DATA_W-1:0] store_data,
    output logic              swr
);
    always_comb begin
        store_en   = we && (widx != IDX_GEN);
        store_data = wdata;
        swr        = we && (widx == IDX_GEN) && wdata[BIT_SWR];
        unique case (widx)
            IDX_PHY:  store_data[BIT_PHY_ACK] = wdata[BIT_PHY_WR] | wdata[BIT_PHY_RD];
            IDX_EMMC: store_data[BIT_TUNE]    = 1'b0;
            default:  ;
        endcase
    end
endmodule

// File: rtl/sdv_bank.sv
module sdv_bank
    import sdv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_en,
    input  logic              swr,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] store_data,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rword,
    output logic              rst_pulse
);
    typedef struct packed {
        logic [VND_WORDS-1:0][DATA_W-1:0] regs;
        logic                             pulse;
    } bank_t;

    bank_t st_d, st_q;

    function automatic bank_t por_state();
        bank_t s;
        s = '0;
        s.regs[IDX_GEN] = GEN_POR;
        return s;
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (swr) begin
            st_d       = por_state();
            st_d.pulse = 1'b1;
        end else if (store_en) begin
            st_d.regs[widx] = store_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= por_state();
        else        st_q <= st_d;
    end

    assign rword     = st_q.regs[ridx];
    assign rst_pulse = st_q.pulse;

    p_swr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> (st_q.regs[IDX_PHY] == '0) && (st_q.regs[VND_WORDS-1] == '0)
                && (st_q.regs[IDX_GEN] == GEN_POR));
    p_pulse_on_swr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> rst_pulse);
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse && !swr |=> !rst_pulse);
    p_gen_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.regs[IDX_GEN] == GEN_POR);
    p_phy_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (store_en && !swr && widx == IDX_PHY) |=>
        st_q.regs[IDX_PHY][BIT_PHY_ACK] ==
            ($past(store_data[BIT_PHY_WR]) | $past(store_data[BIT_PHY_RD])));
    p_tune_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.regs[IDX_EMMC][BIT_TUNE] == 1'b0);
endmodule

// File: rtl/sdhost_vendor_regs.sv
module sdhost_vendor_regs
    import sdv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              slot_valid,
    output logic              slot_write,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [DATA_W-1:0] slot_wdata,
    input  logic [DATA_W-1:0] slot_rdata,
    input  logic              slot_err,
    input  logic              slot_irq,
    output logic              slot_rst,
    output logic              host_irq
);
    logic              bad, vnd_hit, slot_hit;
    logic [IDX_W-1:0]  widx;
    logic [ADDR_W-1:0] slot_off;
    logic              store_en, swr;
    logic [DATA_W-1:0] store_data, rword;

    sdv_decode u_dec (
        .valid(req_valid), .addr(req_addr), .be(req_be),
        .bad(bad), .vnd_hit(vnd_hit), .slot_hit(slot_hit),
        .widx(widx), .slot_off(slot_off)
    );

    sdv_wr_fx u_fx (
        .we(vnd_hit && req_write), .widx(widx), .wdata(req_wdata),
        .store_en(store_en), .store_data(store_data), .swr(swr)
    );

    sdv_bank u_bank (
        .clk(clk), .rst_n(rst_n), .store_en(store_en), .swr(swr),
        .widx(widx), .store_data(store_data), .ridx(widx),
        .rword(rword), .rst_pulse(slot_rst)
    );

    always_comb begin
        slot_valid = slot_hit;
        slot_write = req_write;
        slot_addr  = slot_off;
        slot_wdata = req_wdata;
        rsp_rdata  = '0;
        rsp_err    = 1'b0;
        if (bad) begin
            rsp_err = 1'b1;
        end else if (slot_hit) begin
            rsp_rdata = req_write ? '0 : slot_rdata;
            rsp_err   = slot_err;
        end else if (vnd_hit && !req_write) begin
            rsp_rdata = rword;
        end
    end

    assign host_irq = slot_irq;

    p_bad_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_be != 4'hF) |-> rsp_err && !slot_valid && rsp_rdata == '0);
    p_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_be == 4'hF && req_addr[1:0] == 2'b00 && req_addr >= 12'h200)
        |-> slot_valid && (slot_addr + 12'h200 == req_addr));
    p_irq_thru_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq == slot_irq);
endmodule

// File: tb/test_sdhost_vendor_regs.sv
module test_sdhost_vendor_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        slot_valid, slot_write;
    logic [11:0] slot_addr;
    logic [31:0] slot_wdata;
    logic [31:0] slot_rdata;
    logic        slot_err;
    logic        slot_irq = 1'b0;
    logic        slot_rst, host_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign slot_rdata = {20'h5A5A0, slot_addr};
    assign slot_err   = (slot_addr == 12'h010);

    sdhost_vendor_regs i_sdhost_vendor_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .slot_valid(slot_valid),
        .slot_write(slot_write), .slot_addr(slot_addr), .slot_wdata(slot_wdata),
        .slot_rdata(slot_rdata), .slot_err(slot_err), .slot_irq(slot_irq),
        .slot_rst(slot_rst), .host_irq(host_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] a, input logic [3:0] be,
                          input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
        #1;
    endtask

    task automatic finish_access();
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        access(1'b1, a, 4'hF, d);
        finish_access();
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        access(1'b0, a, 4'hF, '0);
        check(req, rsp_rdata, exp);
        check(req, {31'd0, rsp_err}, 32'd0);
        finish_access();
    endtask

    function automatic logic [31:0] pat(input int i, input bit inv);
        logic [31:0] p;
        p = (32'h9E3779B9 * (i + 1)) ^ {i[7:0], i[7:0], i[7:0], i[7:0]};
        if (inv) p = ~p;
        if (i == 0) p[0] = 1'b0;
        return p;
    endfunction

    function automatic logic [31:0] expect_word(input int i, input logic [31:0] d);
        logic [31:0] e;
        e = d;
        if (i == 0) e = 32'h0001_0000;
        if (i == 4) e[26] = d[24] | d[25];
        if (i == 6) e[15] = 1'b0;
        return e;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 reset values, R11 same-cycle read
        rd_chk("R2", 12'h000, 32'h0001_0000);
        for (int i = 1; i < 128; i++) rd_chk("R2", 12'(i * 4), 32'h0);
        check("R4", {31'd0, slot_rst}, 32'd0);

        // R8/R6/R7/R5 sweeps with two data polarities
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 128; i++) wr(12'(i * 4), pat(i, pass[0]));
            for (int i = 0; i < 128; i++)
                rd_chk("R8", 12'(i * 4), expect_word(i, pat(i, pass[0])));
        end

        // R6 acknowledge cases
        wr(12'h010, 32'h0400_0000); rd_chk("R6", 12'h010, 32'h0000_0000);
        wr(12'h010, 32'h0100_0000); rd_chk("R6", 12'h010, 32'h0500_0000);
        wr(12'h010, 32'h0200_00FF); rd_chk("R6", 12'h010, 32'h0600_00FF);
        wr(12'h010, 32'hFBFF_FFFF); rd_chk("R6", 12'h010, 32'hFFFF_FFFF);
        wr(12'h010, 32'hFCFF_FFFF); rd_chk("R6", 12'h010, 32'hF8FF_FFFF);

        // R7 tune bit
        wr(12'h018, 32'hFFFF_FFFF); rd_chk("R7", 12'h018, 32'hFFFF_7FFF);
        wr(12'h018, 32'h0000_8001); rd_chk("R7", 12'h018, 32'h0000_0001);

        // R5 general word not writable
        wr(12'h000, 32'hFFFF_FFFE); rd_chk("R5", 12'h000, 32'h0001_0000);

        // R1 bad accesses
        wr(12'h020, 32'h1234_5678);
        access(1'b1, 12'h020, 4'h3, 32'hDEAD_BEEF);
        check("R1", {31'd0, rsp_err}, 32'd1);
        finish_access();
        access(1'b1, 12'h022, 4'hF, 32'hDEAD_BEEF);
        check("R1", {31'd0, rsp_err}, 32'd1);
        finish_access();
        rd_chk("R1", 12'h020, 32'h1234_5678);
        access(1'b0, 12'h021, 4'hF, '0);
        check("R1", rsp_rdata, 32'h0);
        check("R1", {31'd0, rsp_err}, 32'd1);
        finish_access();
        access(1'b0, 12'h204, 4'h1, '0);
        check("R1", {31'd0, slot_valid}, 32'd0);
        check("R1", {31'd0, rsp_err}, 32'd1);
        finish_access();
        access(1'b1, 12'h000, 4'h1, 32'h1);
        finish_access();
        @(negedge clk);
        check("R1", {31'd0, slot_rst}, 32'd0);
        rd_chk("R1", 12'h020, 32'h1234_5678);

        // R9 forwarding
        for (int k = 0; k < 8; k++) begin
            logic [11:0] a;
            a = 12'h200 + 12'(k * 12'h1F4);
            access(1'b0, a, 4'hF, '0);
            check("R9", {31'd0, slot_valid}, 32'd1);
            check("R9", {20'd0, slot_addr}, {20'd0, a - 12'h200});
            check("R9", rsp_rdata, {20'h5A5A0, a - 12'h200});
            finish_access();
        end
        access(1'b0, 12'h210, 4'hF, '0);
        check("R9", {31'd0, rsp_err}, 32'd1);
        finish_access();
        access(1'b1, 12'hFFC, 4'hF, 32'hCAFE_F00D);
        check("R9", {31'd0, slot_valid}, 32'd1);
        check("R9", {31'd0, slot_write}, 32'd1);
        check("R9", slot_wdata, 32'hCAFE_F00D);
        finish_access();
        access(1'b0, 12'h1FC, 4'hF, '0);
        check("R9", {31'd0, slot_valid}, 32'd0);
        finish_access();

        // R10 interrupt
        @(negedge clk); slot_irq = 1'b1; #1;
        check("R10", {31'd0, host_irq}, 32'd1);
        slot_irq = 1'b0; #1;
        check("R10", {31'd0, host_irq}, 32'd0);

        // R3/R4 software reset
        wr(12'h040, 32'hA5A5_A5A5);
        wr(12'h018, 32'h0000_0F0F);
        access(1'b1, 12'h000, 4'hF, 32'h0000_0001);
        check("R4", {31'd0, slot_rst}, 32'd0);
        finish_access();
        @(negedge clk);
        check("R4", {31'd0, slot_rst}, 32'd1);
        @(negedge clk);
        check("R4", {31'd0, slot_rst}, 32'd0);
        rd_chk("R3", 12'h040, 32'h0);
        rd_chk("R3", 12'h018, 32'h0);
        rd_chk("R3", 12'h010, 32'h0);
        rd_chk("R3", 12'h000, 32'h0001_0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule